// File: doc/BRIEF.md
# Posted-Write Host Bus Bridge

This block sits between a CPU bus master and a memory controller that runs on its own, unrelated clock. A single write is not made to wait for the memory. The bridge stores the address, the 32-bit data word and the four byte enables in a small asynchronous FIFO and acknowledges the CPU a fixed three cycles after the transfer starts. A memory-side sequencer then empties the FIFO toward the memory port in order. The CPU only waits longer than that when the FIFO is full.

A read cannot be posted. The bridge holds a read until the CPU side sees the FIFO empty. It then passes the request across with a toggle handshake. The memory side issues the read and captures the returned word. A second toggle brings the word back, and the CPU is acknowledged with it. Only single-word transfers exist, and the CPU starts a new transfer only after the previous one is acknowledged. There are no bursts and no cache.

Top module: `host_post_bridge`

## Requirements
- R1: While either reset is asserted and right after release, `bus_ack` is 0, `mem_req` is 0 and `bus_rdata` is 0.
- R2: A write whose `bus_start` cycle is cycle n finds room in the FIFO at cycle n+2. For that write, `bus_ack` is high in cycle n+3 and in no earlier cycle. A write is never acknowledged before cycle n+3.
- R3: `bus_ack` is high for exactly one cycle per transfer and is never high while no transfer is outstanding.
- R4: Every acknowledged write shows up on the memory port exactly once, in issue order, with `mem_we`=1 and its address, data and byte enables unchanged.
- R5: When the FIFO holds its full 4 entries (default depth), a further write is not acknowledged until the memory has accepted an entry. No entry is overwritten or lost.
- R6: A memory read (`mem_req`=1, `mem_we`=0) is never issued while any earlier posted write has not yet been accepted by the memory.
- R7: A read is acknowledged only after the memory has returned `mem_rvalid`. Its `bus_rdata` equals the word the memory returned. Because of R6, that word includes every earlier write merged by byte enable (bit i of `bus_be` covers data byte i).
- R8: Once `mem_req` is high without `mem_gnt`, it stays high with `mem_addr` and `mem_we` unchanged in the next memory clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | CPU bus clock |
| rst_cpu_n | input | 1 | CPU domain reset, active low |
| bus_start | input | 1 | One-cycle transfer start |
| bus_rd | input | 1 | 1 = read, 0 = write, sampled with bus_start |
| bus_addr | input | ADDR_W | Word address of the transfer |
| bus_wdata | input | DATA_W | Write data |
| bus_be | input | DATA_W/8 | Byte enables of a write, bit i selects byte i |
| bus_ack | output | 1 | One-cycle transfer acknowledge |
| bus_rdata | output | DATA_W | Read data, valid with bus_ack of a read |
| clk_mem | input | 1 | Memory controller clock |
| rst_mem_n | input | 1 | Memory domain reset, active low |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory access address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_be | output | DATA_W/8 | Memory byte enables (all ones for a read) |
| mem_gnt | input | 1 | Memory accepts the request in this cycle |
| mem_rvalid | input | 1 | Read data valid, one cycle |
| mem_rdata | input | DATA_W | Read data from memory |

## Verification
A pointer or full flag that has gone wrong shows up quickly. A write gets acknowledged while the FIFO is full, or an entry appears twice or out of order on the memory port. A stale read order shows up too: the returned word misses a byte written just before it. These are seen at the very next memory acceptance or read acknowledge. A sequencer that stalls or skips a handshake toggle leaves `bus_ack` missing, so the wrong latency is seen within a few cycles. The directed cases block the memory grant to force the FIFO to fill and to make a read wait on its drain. The random traffic mixes byte-enable patterns, addresses and grant stalls.

// File: rtl/hpb_pkg.sv
package hpb_pkg;

  typedef enum logic [2:0] {
    C_IDLE,
    C_W1,
    C_W2,
    C_RDRAIN,
    C_RWAIT
  } cpu_st_t;

  typedef enum logic [1:0] {
    M_IDLE,
    M_RREQ,
    M_RWAIT
  } mem_st_t;

  // binary to reflected Gray code, callers slice to their width
  function automatic logic [31:0] hpb_gray_of(logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

endpackage

// File: rtl/hpb_sync.sv
module hpb_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;

endmodule

// File: rtl/hpb_afifo.sv
module hpb_afifo
  import hpb_pkg::*;
#(
  parameter int DW = 68,
  parameter int AW = 2
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  output logic          full,
  output logic          wempty,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty
);

  localparam int PW = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] FULL_MASK = PW'(3) << (PW - 2);

  logic [DW-1:0] store [DEPTH];
  logic [PW-1:0] wbin, wgray, wbin_nx, rgray_w;
  logic [PW-1:0] rbin, rgray, rbin_nx, wgray_r;

  assign wbin_nx = wbin + PW'(1);
  assign rbin_nx = rbin + PW'(1);

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (push) begin
      wbin  <= wbin_nx;
      wgray <= PW'(hpb_gray_of(32'(wbin_nx)));
    end
  end

  always_ff @(posedge wclk) begin
    if (push) store[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (pop) begin
      rbin  <= rbin_nx;
      rgray <= PW'(hpb_gray_of(32'(rbin_nx)));
    end
  end

  hpb_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w));
  hpb_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r));

  assign full   = ((wgray ^ rgray_w) == FULL_MASK);
  assign wempty = (wgray == rgray_w);
  assign empty  = (rgray == wgray_r);
  assign rdata  = store[rbin[AW-1:0]];

  // R5: a write is only stored when a slot is free
  p_no_overflow_r5: assert property (@(posedge wclk) disable iff (!wrst_n)
    push |-> !full);

  // R4: the memory side never takes an entry that is not there
  p_no_underflow_r4: assert property (@(posedge rclk) disable iff (!rrst_n)
    pop |-> !empty);

endmodule

// File: rtl/hpb_cpu_ctl.sv
module hpb_cpu_ctl
  import hpb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [BE_W-1:0]   bus_be,
  output logic              bus_ack,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              fifo_full,
  input  logic              fifo_wempty,
  output logic              push,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [DATA_W-1:0] xfer_data,
  output logic [BE_W-1:0]   xfer_be,
  output logic              rd_req_tgl,
  input  logic              rd_ack_tgl_s,
  input  logic [DATA_W-1:0] rd_hold
);

  cpu_st_t st;
  logic    ack_seen;
  logic    rd_done;

  assign push    = (st == C_W2) && !fifo_full;
  assign rd_done = (st == C_RWAIT) && (rd_ack_tgl_s != ack_seen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= C_IDLE;
      xfer_addr  <= '0;
      xfer_data  <= '0;
      xfer_be    <= '0;
      bus_ack    <= 1'b0;
      bus_rdata  <= '0;
      rd_req_tgl <= 1'b0;
      ack_seen   <= 1'b0;
    end else begin
      bus_ack <= 1'b0;
      unique case (st)
        C_IDLE: if (bus_start) begin
          xfer_addr <= bus_addr;
          xfer_data <= bus_wdata;
          xfer_be   <= bus_be;
          st        <= bus_rd ? C_RDRAIN : C_W1;
        end
        C_W1: st <= C_W2;
        C_W2: if (push) begin
          bus_ack <= 1'b1;
          st      <= C_IDLE;
        end
        C_RDRAIN: if (fifo_wempty) begin
          rd_req_tgl <= ~rd_req_tgl;
          st         <= C_RWAIT;
        end
        C_RWAIT: if (rd_done) begin
          ack_seen  <= rd_ack_tgl_s;
          bus_rdata <= rd_hold;
          bus_ack   <= 1'b1;
          st        <= C_IDLE;
        end
        default: st <= C_IDLE;
      endcase
    end
  end

  // R3: acknowledge is a single-cycle pulse
  p_ack_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);

  // R2: an accepted write start is not acknowledged in the next two cycles
  p_wr_not_early_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_IDLE && bus_start && !bus_rd) |=> !bus_ack ##1 !bus_ack);

  // R2: a stored write is acknowledged in the following cycle
  p_push_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> bus_ack);

endmodule

// File: rtl/hpb_mem_ctl.sv
module hpb_mem_ctl
  import hpb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_empty,
  input  logic [ADDR_W-1:0] ent_addr,
  input  logic [DATA_W-1:0] ent_data,
  input  logic [BE_W-1:0]   ent_be,
  output logic              pop,
  input  logic              rd_req_tgl_s,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_ack_tgl,
  output logic [DATA_W-1:0] rd_hold,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [BE_W-1:0]   mem_be,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);

  mem_st_t           st;
  logic              req_seen;
  logic              rd_pend;
  logic [ADDR_W-1:0] rd_addr_q;

  assign rd_pend   = (rd_req_tgl_s != req_seen);
  assign mem_we    = (st == M_IDLE);
  assign mem_req   = (st == M_RREQ) || ((st == M_IDLE) && !fifo_empty);
  assign mem_addr  = mem_we ? ent_addr : rd_addr_q;
  assign mem_wdata = ent_data;
  assign mem_be    = mem_we ? ent_be : '1;
  assign pop       = (st == M_IDLE) && !fifo_empty && mem_gnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= M_IDLE;
      req_seen   <= 1'b0;
      rd_addr_q  <= '0;
      rd_ack_tgl <= 1'b0;
      rd_hold    <= '0;
    end else begin
      unique case (st)
        M_IDLE: if (fifo_empty && rd_pend) begin
          req_seen  <= rd_req_tgl_s;
          rd_addr_q <= rd_addr;
          st        <= M_RREQ;
        end
        M_RREQ: if (mem_gnt) st <= M_RWAIT;
        M_RWAIT: if (mem_rvalid) begin
          rd_hold    <= mem_rdata;
          rd_ack_tgl <= ~rd_ack_tgl;
          st         <= M_IDLE;
        end
        default: st <= M_IDLE;
      endcase
    end
  end

  // R6: reads go out only when no posted write is left
  p_rd_after_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> fifo_empty);

  // R8: a stalled request keeps its address and direction
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

endmodule

// File: rtl/host_post_bridge.sv
module host_post_bridge #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int DEPTH_LOG2 = 2
) (
  input  logic                  clk_cpu,
  input  logic                  rst_cpu_n,
  input  logic                  bus_start,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  input  logic [DATA_W/8-1:0]   bus_be,
  output logic                  bus_ack,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic                  clk_mem,
  input  logic                  rst_mem_n,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic [DATA_W/8-1:0]   mem_be,
  input  logic                  mem_gnt,
  input  logic                  mem_rvalid,
  input  logic [DATA_W-1:0]     mem_rdata
);

  localparam int BE_W = DATA_W / 8;
  localparam int EW   = ADDR_W + DATA_W + BE_W;

  logic              push, pop, full, wempty, empty;
  logic [ADDR_W-1:0] x_addr;
  logic [DATA_W-1:0] x_data;
  logic [BE_W-1:0]   x_be;
  logic [EW-1:0]     ent_in, ent_out;
  logic              req_tgl, req_tgl_s, ack_tgl, ack_tgl_s;
  logic [DATA_W-1:0] rd_hold;

  assign ent_in = {x_addr, x_data, x_be};

  hpb_cpu_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_cpu (
    .clk(clk_cpu), .rst_n(rst_cpu_n),
    .bus_start(bus_start), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .fifo_full(full), .fifo_wempty(wempty), .push(push),
    .xfer_addr(x_addr), .xfer_data(x_data), .xfer_be(x_be),
    .rd_req_tgl(req_tgl), .rd_ack_tgl_s(ack_tgl_s), .rd_hold(rd_hold)
  );

  hpb_afifo #(.DW(EW), .AW(DEPTH_LOG2)) u_fifo (
    .wclk(clk_cpu), .wrst_n(rst_cpu_n), .push(push), .wdata(ent_in),
    .full(full), .wempty(wempty),
    .rclk(clk_mem), .rrst_n(rst_mem_n), .pop(pop), .rdata(ent_out), .empty(empty)
  );

  hpb_sync #(.W(1)) u_req_sync (.clk(clk_mem), .rst_n(rst_mem_n), .d(req_tgl), .q(req_tgl_s));
  hpb_sync #(.W(1)) u_ack_sync (.clk(clk_cpu), .rst_n(rst_cpu_n), .d(ack_tgl), .q(ack_tgl_s));

  hpb_mem_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_mem (
    .clk(clk_mem), .rst_n(rst_mem_n), .fifo_empty(empty),
    .ent_addr(ent_out[EW-1 -: ADDR_W]), .ent_data(ent_out[BE_W +: DATA_W]),
    .ent_be(ent_out[BE_W-1:0]), .pop(pop),
    .rd_req_tgl_s(req_tgl_s), .rd_addr(x_addr),
    .rd_ack_tgl(ack_tgl), .rd_hold(rd_hold),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

endmodule

// File: tb/test_host_post_bridge.sv
module test_host_post_bridge;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BW = 4;

  logic clk_cpu = 1'b0, clk_mem = 1'b0;
  logic rst_cpu_n = 1'b0, rst_mem_n = 1'b0;
  logic bus_start = 1'b0, bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [BW-1:0] bus_be = '0;
  logic bus_ack;
  logic [DW-1:0] bus_rdata;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [BW-1:0] mem_be;
  logic mem_gnt = 1'b0, mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  always #2 clk_cpu = ~clk_cpu;
  always #3 clk_mem = ~clk_mem;

  host_post_bridge i_host_post_bridge (.*);

  int checks = 0, errors = 0;
  logic [DW-1:0] shadow [16];
  logic [DW-1:0] memm [16];
  logic [AW+DW+BW-1:0] sb [64];
  int sb_wr = 0, sb_rd = 0;
  bit gnt_en = 1'b1;
  bit rv_given = 1'b0;
  int rd_cnt = 0;
  int rd_idx = 0;
  bit prev_stall = 1'b0, prev_we = 1'b0, prev_ack = 1'b0;
  logic [AW-1:0] prev_addr = '0;

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] nw, logic [BW-1:0] be);
    logic [DW-1:0] r = old;
    for (int i = 0; i < BW; i++) if (be[i]) r[8*i +: 8] = nw[8*i +: 8];
    return r;
  endfunction

  function automatic logic [AW-1:0] addr_of(int idx);
    return 32'h4000_0000 | (AW'(idx) << 2);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [AW+DW+BW-1:0] act, logic [AW+DW+BW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory-side model and monitor
  always @(negedge clk_mem) begin
    if (!rst_mem_n) begin
      mem_gnt = 1'b0;
      mem_rvalid = 1'b0;
    end else begin
      mem_rvalid = 1'b0;
      if (rd_cnt > 0) begin
        rd_cnt--;
        if (rd_cnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata = memm[rd_idx];
          rv_given = 1'b1;
        end
      end
      if (prev_stall)
        chk(mem_req && mem_addr == prev_addr && mem_we == prev_we, "R8", "stalled request held",
            {mem_req, mem_we, mem_addr}, {1'b1, prev_we, prev_addr});
      mem_gnt = gnt_en && ($urandom % 4 != 0);
      if (mem_req && mem_gnt) begin
        if (mem_we) begin
          chk(sb_rd != sb_wr && {mem_addr, mem_wdata, mem_be} == sb[sb_rd % 64], "R4",
              "write on memory port", {mem_addr, mem_wdata, mem_be}, sb[sb_rd % 64]);
          memm[mem_addr[5:2]] = merge(memm[mem_addr[5:2]], mem_wdata, mem_be);
          sb_rd++;
        end else begin
          chk(sb_rd == sb_wr, "R6", "read with writes pending", sb_wr - sb_rd, 0);
          rd_idx = int'(mem_addr[5:2]);
          rd_cnt = 1 + int'($urandom % 3);
        end
      end
      prev_stall = mem_req && !mem_gnt;
      prev_we = mem_we;
      prev_addr = mem_addr;
    end
  end

  always @(negedge clk_cpu) begin
    if (rst_cpu_n) begin
      if (bus_ack && prev_ack) chk(1'b0, "R3", "acknowledge longer than one cycle", 1, 0);
      prev_ack = bus_ack;
    end
  end

  task automatic do_write(int idx, logic [DW-1:0] d, logic [BW-1:0] be, output int lat);
    @(negedge clk_cpu);
    bus_start = 1'b1; bus_rd = 1'b0; bus_addr = addr_of(idx); bus_wdata = d; bus_be = be;
    sb[sb_wr % 64] = {addr_of(idx), d, be};
    sb_wr++;
    shadow[idx] = merge(shadow[idx], d, be);
    lat = 0;
    forever begin
      @(negedge clk_cpu);
      bus_start = 1'b0;
      lat++;
      if (bus_ack) break;
    end
  endtask

  task automatic do_read(int idx, output int lat);
    logic [DW-1:0] exp = shadow[idx];
    rv_given = 1'b0;
    @(negedge clk_cpu);
    bus_start = 1'b1; bus_rd = 1'b1; bus_addr = addr_of(idx);
    lat = 0;
    forever begin
      @(negedge clk_cpu);
      bus_start = 1'b0;
      lat++;
      if (bus_ack) break;
    end
    chk(rv_given, "R7", "read acknowledged after memory data", rv_given, 1);
    chk(bus_rdata == exp, "R7", "read data", bus_rdata, exp);
  endtask

  task automatic idle_chk(int n);
    repeat (n) begin
      @(negedge clk_cpu);
      chk(!bus_ack, "R3", "acknowledge while idle", bus_ack, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk_cpu);
    errors++;
    $display("FAIL R3 watchdog: transfer never acknowledged");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin shadow[i] = '0; memm[i] = '0; end
    repeat (3) @(negedge clk_cpu);
    chk(!bus_ack && !mem_req && bus_rdata == '0, "R1", "outputs in reset",
        {bus_ack, mem_req, bus_rdata}, 0);
    @(negedge clk_cpu); rst_cpu_n = 1'b1;
    @(negedge clk_mem); rst_mem_n = 1'b1;
    @(negedge clk_cpu);
    chk(!bus_ack && !mem_req && bus_rdata == '0, "R1", "outputs after reset",
        {bus_ack, mem_req, bus_rdata}, 0);
    idle_chk(5);

    // single write then read back, R2 exact latency
    do_write(3, 32'hCAFE_1234, 4'hF, lat);
    chk(lat == 3, "R2", "write ack latency", lat, 3);
    do_read(3, lat);
    // partial byte enables merged into the old word (R7)
    do_write(3, 32'h1100_FF00, 4'b0101, lat);
    chk(lat == 3, "R2", "write ack latency partial", lat, 3);
    do_read(3, lat);
    idle_chk(5);

    // fill the FIFO with the memory blocked (R5)
    gnt_en = 1'b0;
    idle_chk(10);
    for (int i = 0; i < 4; i++) begin
      do_write(i + 4, 32'hA000_0000 + i, 4'hF, lat);
      chk(lat == 3, "R2", "write ack latency while filling", lat, 3);
    end
    fork
      do_write(8, 32'hB0B0_B0B0, 4'hF, lat);
      begin repeat (20) @(negedge clk_cpu); gnt_en = 1'b1; end
    join
    chk(lat > 10, "R5", "write held while FIFO full", lat, 11);
    for (int i = 4; i < 9; i++) do_read(i, lat);

    // read must wait for the posted writes (R6)
    gnt_en = 1'b0;
    do_write(10, 32'h0000_00AA, 4'b0001, lat);
    do_write(10, 32'hBB00_0000, 4'b1000, lat);
    fork
      do_read(10, lat);
      begin repeat (15) @(negedge clk_cpu); gnt_en = 1'b1; end
    join
    chk(lat > 10, "R6", "read waits for drain", lat, 11);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int idx = int'($urandom % 16);
      if ($urandom % 10 < 3) do_read(idx, lat);
      else begin
        do_write(idx, $urandom, BW'($urandom), lat);
        chk(lat >= 3, "R2", "write ack not early", lat, 3);
      end
    end
    idle_chk(40);
    chk(sb_rd == sb_wr, "R4", "all writes reached memory", sb_rd, sb_wr);
    for (int i = 0; i < 16; i++) do_read(i, lat);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule